// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps a four-bank SDRAM refreshed on time and puts it to sleep on request. A down-counter, sized from the clock frequency, produces one refresh obligation per 1/8192 of a 64 ms window. The obligation is held until the command sequencer reports that every bank is precharged. The block then drives the auto-refresh command on the command pins. It keeps its busy flag high until the row cycle time after that command has passed, so the sequencer can hold back any activate until busy falls.

A sleep request is served the same way. Once the banks are idle, the block issues the refresh command with clock enable low in the same cycle, which places the memory in self-refresh. Periodic obligations are suppressed while it sleeps. When the request is withdrawn, clock enable rises, one idle cycle follows, and one catch-up auto refresh is issued. If the banks stay busy past several intervals, the owed refreshes are counted up to a limit and issued one after another once the banks free up.

Top module: `sdram_refresh_sched`

## Requirements
- R1: In reset and in the first cycle after it, clock enable is high, busy is low and the command pins show a no-operation (chip select low, row strobe, column strobe and write enable high).
- R2: With no sleep request, busy rises in the cycle after the INTERVAL-th clock edge following reset, and again every INTERVAL edges after that. INTERVAL = WINDOW_US*(CLK_KHZ/1000)/ROWS, rounded down.
- R3: A refresh command is chip select, row strobe and column strobe low with write enable high. It lasts exactly one cycle and appears on the second edge after busy rises, provided the banks are idle.
- R4: No refresh command is driven unless the all-banks-idle input was high at the edge that launches it. Busy stays high while a refresh waits.
- R5: Refreshes owed while the banks were busy are all issued once the banks become idle, with TRC_CLKS+1 cycles between consecutive commands.
- R6: After an auto refresh, busy stays high for TRC_CLKS cycles counting the command cycle. TRC_CLKS = ceil(TRC_NS*CLK_KHZ/10^6), at least 1.
- R7: With sleep requested and the banks idle, the refresh command is driven with clock enable low in the same cycle. Clock enable and busy then stay low and high respectively while the request persists.
- R8: While in self-refresh, no command is driven and no periodic obligation accrues.
- R9: On withdrawal of the sleep request, clock enable rises on the next edge. Exactly one auto refresh follows, no earlier than two cycles after clock enable rises.
- R10: The count of owed refreshes saturates at MAX_POSTPONE. Obligations beyond that are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | High when all four banks are precharged |
| sleep_req | input | 1 | Level request to hold the memory in self-refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable to the memory |
| busy | output | 1 | Refresh pending, in progress or in row cycle wait; activates must wait |

## Verification
The hardest state to reach is a saturated backlog that is drained while a fresh interval expires mid-drain. In that state the decrement and the increment of the owed count land on the same edge, and a further obligation arrives just as the row cycle wait ends. The stimulus holds the all-banks-idle input low for more than MAX_POSTPONE intervals, then releases it at a point where the interval counter expires during the back-to-back burst. An exact command count over the window then shows whether any refresh was lost or doubled.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CLK_KHZ      = 100000,
  parameter int ROWS         = 8192,
  parameter int WINDOW_US    = 64000,
  parameter int TRC_NS       = 70,
  parameter int MAX_POSTPONE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic sleep_req,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic cke,
  output logic busy
);
  localparam int INTERVAL = (WINDOW_US * (CLK_KHZ / 1000)) / ROWS;
  localparam int TRC_RAW  = (TRC_NS * (CLK_KHZ / 1000) + 999) / 1000;
  localparam int TRC_CLKS = (TRC_RAW < 1) ? 1 : TRC_RAW;
  localparam int IW = $clog2(INTERVAL);
  localparam int TW = $clog2(TRC_CLKS + 1);
  localparam int PW = $clog2(MAX_POSTPONE + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_TRC, S_SELF, S_EXIT} state_t;

  state_t        state;
  logic [IW-1:0] icnt;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pend, pend_nxt;
  logic          ref_q, cke_q;

  wire sleeping = (state == S_SELF) || (state == S_EXIT);
  wire tick     = !sleeping && (icnt == '0);
  wire issue    = (state == S_WAIT) && banks_idle && (sleep_req || pend != '0);
  wire go_self  = issue && sleep_req;
  wire go_ref   = issue && !sleep_req;

  always_comb begin
    pend_nxt = pend;
    if (go_self) begin
      pend_nxt = '0;
    end else if (state == S_EXIT) begin
      pend_nxt = PW'(1);
    end else begin
      if (go_ref) pend_nxt = pend_nxt - 1'b1;
      if (tick && pend_nxt != PW'(MAX_POSTPONE)) pend_nxt = pend_nxt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      icnt  <= IW'(INTERVAL - 1);
      tcnt  <= '0;
      pend  <= '0;
      ref_q <= 1'b0;
      cke_q <= 1'b1;
    end else begin
      ref_q <= 1'b0;
      pend  <= pend_nxt;
      if (sleeping || icnt == '0) icnt <= IW'(INTERVAL - 1);
      else                        icnt <= icnt - 1'b1;
      case (state)
        S_IDLE: if (pend != '0 || sleep_req) state <= S_WAIT;
        S_WAIT: begin
          if (!sleep_req && pend == '0) begin
            state <= S_IDLE;
          end else if (go_self) begin
            state <= S_SELF;
            ref_q <= 1'b1;
            cke_q <= 1'b0;
          end else if (go_ref) begin
            state <= S_TRC;
            ref_q <= 1'b1;
            tcnt  <= TW'(TRC_CLKS - 1);
          end
        end
        S_TRC: begin
          if (tcnt == '0) state <= (pend != '0) ? S_WAIT : S_IDLE;
          else            tcnt  <= tcnt - 1'b1;
        end
        S_SELF: if (!sleep_req) begin
          state <= S_EXIT;
          cke_q <= 1'b1;
        end
        S_EXIT: state <= S_WAIT;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cs_n  = 1'b0;
  assign ras_n = ~ref_q;
  assign cas_n = ~ref_q;
  assign we_n  = 1'b1;
  assign cke   = cke_q;
  assign busy  = (state != S_IDLE) || (pend != '0);
endmodule

module sdram_refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic banks_idle,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke,
  input logic busy
);
  wire ref_cmd = !cs_n && !ras_n && !cas_n && we_n;

  assert_gate_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> $past(banks_idle));
  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |=> !ref_cmd);
  assert_busy_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> busy);
  assert_entry_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> ref_cmd);
  assert_quiet_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> !ref_cmd);
  assert_exit_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (!ref_cmd && busy));
  assert_exit_gap2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |=> !ref_cmd);
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk chk_i (
  .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .cs_n(cs_n),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .busy(busy));

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb_top;
  logic clk = 1'b0;
  logic rst_n, banks_idle, sleep_req;
  logic cs_n, ras_n, cas_n, we_n, cke, busy;
  int tests = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  sdram_refresh_sched #(.CLK_KHZ(2000), .TRC_NS(1500), .MAX_POSTPONE(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sleep_req(sleep_req),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .busy(busy));

  // INTERVAL = 15, TRC_CLKS = 3, MAX_POSTPONE = 4
  typedef struct packed {
    logic       idle;
    logic       sleep;
    logic [8:0] cycles;
    logic [3:0] refs;
    logic       cke_end;
    logic       busy_end;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 1'b0, 9'd100, 4'd6, 1'b1, 1'b0},  // R2 periodic
    '{1'b0, 1'b0, 9'd75,  4'd0, 1'b1, 1'b1},  // R4 gating, R10 saturates
    '{1'b1, 1'b0, 9'd30,  4'd6, 1'b1, 1'b0},  // R5 drain, R10
    '{1'b1, 1'b1, 9'd40,  4'd1, 1'b0, 1'b1},  // R7 entry, R8 quiet
    '{1'b1, 1'b0, 9'd15,  4'd1, 1'b1, 1'b0}   // R9 exit refresh
  };

  function automatic logic is_ref();
    return !cs_n && !ras_n && !cas_n && we_n;
  endfunction

  function automatic logic is_nop();
    return !cs_n && ras_n && cas_n && we_n;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic idle, input logic slp);
    rst_n = 1'b0; banks_idle = idle; sleep_req = slp;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int n;
    @(negedge clk);
    do_reset(1'b1, 1'b0);
    check(cke && !busy && is_nop(), "R1", "reset state cke/busy/nop",
          {cke, busy, is_nop()}, 3'b101);

    // Table walk
    foreach (VECS[i]) begin
      banks_idle = VECS[i].idle;
      sleep_req  = VECS[i].sleep;
      n = 0;
      for (int c = 0; c < int'(VECS[i].cycles); c++) begin
        step();
        if (is_ref()) n++;
      end
      check(n == int'(VECS[i].refs), "R2 R4 R5 R7 R8 R9 R10",
            $sformatf("vector %0d refresh count", i), n, VECS[i].refs);
      check(cke == VECS[i].cke_end, "R7 R9", $sformatf("vector %0d cke", i),
            cke, VECS[i].cke_end);
      check(busy == VECS[i].busy_end, "R4 R6", $sformatf("vector %0d busy", i),
            busy, VECS[i].busy_end);
    end

    // Directed: exact timing of first refresh
    do_reset(1'b1, 1'b0);
    check(cke && !busy && is_nop(), "R1", "state after second reset",
          {cke, busy, is_nop()}, 3'b101);
    repeat (14) step();
    check(!busy, "R2", "busy before interval edge", busy, 0);
    step();
    check(busy, "R2", "busy at interval edge 15", busy, 1);
    step();
    check(!is_ref(), "R3", "no command at edge 16", is_ref(), 0);
    step();
    check(is_ref() && cke, "R3", "refresh command at edge 17", is_ref(), 1);
    step();
    check(is_nop(), "R3", "nop after one-cycle command", is_nop(), 1);
    step();
    check(busy, "R6", "busy within row cycle wait", busy, 1);
    step();
    check(!busy, "R6", "busy released after TRC_CLKS", busy, 0);

    // Directed: gating holds command while banks busy
    banks_idle = 1'b0;
    n = 0;
    for (int c = 0; c < 20; c++) begin step(); if (is_ref()) n++; end
    check(n == 0 && busy, "R4", "no refresh while banks busy", n, 0);
    banks_idle = 1'b1;
    step();
    check(is_ref(), "R4", "refresh once banks idle", is_ref(), 1);

    // Directed: self-refresh entry and exit
    do_reset(1'b1, 1'b1);
    step();
    check(cke && !is_ref(), "R7", "no entry at edge 1", is_ref(), 0);
    step();
    check(is_ref() && !cke, "R7", "entry refresh with cke low",
          {is_ref(), cke}, 2'b10);
    n = 0;
    for (int c = 0; c < 40; c++) begin
      step();
      if (is_ref() || cke || !busy) n++;
    end
    check(n == 0, "R8", "quiet self-refresh cycles with cke low", n, 0);
    sleep_req = 1'b0;
    step();
    check(cke && !is_ref(), "R9", "cke rises without command",
          {cke, is_ref()}, 2'b10);
    step();
    check(!is_ref(), "R9", "idle cycle after cke rise", is_ref(), 0);
    step();
    check(is_ref() && cke, "R9", "catch-up refresh after exit", is_ref(), 1);
    n = 0;
    for (int c = 0; c < 10; c++) begin step(); if (is_ref()) n++; end
    check(n == 0, "R9", "only one catch-up refresh", n, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule